// File: doc/BRIEF.md
# Micro-address sequencer with repeat-prefix condition latches

This block picks the address of the next micro-instruction. Each cycle it takes a 4-bit condition select from the current micro-instruction and decides whether a jump, call or return replaces the normal one-step advance. It then registers the chosen address together with a flag that says whether a jump was taken. The condition set covers the loops of block-memory instructions. It can test whether a repeat prefix is active. It can test the visible zero flag XORed with the variant bit of that prefix, which lets one test serve both the repeat-while-equal and the repeat-while-unequal forms. It can test bit 3 of the latched opcode, which separates paired instructions that share microcode. It can test whether the last count result was nonzero, using a private zero latch that leaves the visible flag untouched.

The decoder pulses `pfx_strobe` for every prefix byte and raises `pfx_rep` for the repeat forms. It pulses `opcode_load` when the instruction byte arrives and `entry_load` to start that instruction's microcode. It pulses `instr_end` when the instruction finishes. The ALU writes each 16-bit count result through `alu_res_we`. While a prefix is being handled, the interrupt condition reads false until the next opcode has been loaded.

Top module: `useq_cond_seq`

## Requirements
- R1: After a synchronous reset, `upc` is 0 and `cond_taken` is 0.
- R2: With `seq_en` high and `jump_en` high, condition code 0 (always) loads `jump_target` into `upc` on the next edge and sets `cond_taken` to 1 for that cycle.
- R3: A pulse on `pfx_strobe` with `pfx_rep` high sets the repeat-active latch and copies `pfx_byte[0]` into the variant latch. Code 1 is true while repeat-active is set and code 2 is its complement. Code 3 equals `zf` XOR the variant latch, and code 12 is its complement.
- R4: A prefix strobe with `pfx_rep` low leaves both prefix latches unchanged. `instr_end` clears both latches.
- R5: A pulse on `opcode_load` latches `opcode_byte`. Code 4 is true when bit 3 of the latched byte is 1, and code 10 is true when it is 0.
- R6: A write through `alu_res_we` records whether `alu_res` was all zeros. Code 5 (count nonzero) is true when the last recorded result was nonzero, and code 6 is its complement. Both ignore `zf`, and the record holds when no write occurs.
- R7: Code 7 is true when `int_pending` is high and no hold is active, and code 11 is its complement. Any prefix strobe starts the hold. The hold ends after the next `opcode_load`, and a condition evaluated in the same cycle as that `opcode_load` still sees the hold.
- R8: When no load, return or satisfied jump applies, `upc` becomes `upc`+1, wrapping from the top address to 0, and `cond_taken` is 0.
- R9: A satisfied jump with `call_en` high saves `upc`+1 in a single return register. `ret_en` loads that register into `upc`, with `cond_taken` 0.
- R10: While `seq_en` is low, `upc` holds and `cond_taken` is 0.
- R11: `entry_load` has priority over return and jump, loads `entry_addr`, and gives `cond_taken` 0.
- R12: Codes 8 and 9 are `zf` and its complement. Codes 13, 14 and 15 are never satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Advance the sequencer this cycle |
| entry_load | input | 1 | Load the entry address of a new instruction |
| entry_addr | input | UADDR_W | Entry micro-address |
| cond_sel | input | 4 | Condition select of the current micro-instruction |
| jump_en | input | 1 | Current micro-instruction is a conditional jump |
| call_en | input | 1 | The jump is a call and saves the return address |
| ret_en | input | 1 | Return from micro-subroutine |
| jump_target | input | UADDR_W | Jump or call target |
| pfx_strobe | input | 1 | A prefix byte is being handled |
| pfx_rep | input | 1 | The prefix is a repeat prefix |
| pfx_byte | input | 8 | Prefix byte |
| instr_end | input | 1 | The instruction ends this cycle |
| opcode_load | input | 1 | Latch the opcode byte |
| opcode_byte | input | 8 | Opcode byte |
| alu_res_we | input | 1 | Record the zero status of `alu_res` |
| alu_res | input | DATA_W | ALU result |
| zf | input | 1 | Visible zero flag |
| int_pending | input | 1 | Interrupt request pending |
| upc | output | UADDR_W | Registered micro-address |
| cond_taken | output | 1 | Registered: a jump or call was taken |

## Verification
Each decision shows up at the outputs one edge after the cycle in which its inputs are applied. `upc` and `cond_taken` change together at that edge. A latch update (prefix, opcode, zero record, interrupt hold) changes the condition result only from the following cycle, so the latch load and the condition that depends on it are always issued in separate cycles. The driver applies inputs on the falling edge and queues the expected address and taken flag for the coming rising edge. The monitor samples 5 ns after that rising edge, so each queued item is compared exactly one register stage after its stimulus.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Condition codes selected by the 4-bit field of a micro-instruction
  typedef enum logic [3:0] {
    C_ALWAYS  = 4'd0,
    C_REP     = 4'd1,
    C_NREP    = 4'd2,
    C_ZXP     = 4'd3,
    C_OPB     = 4'd4,
    C_CNT_NZ  = 4'd5,
    C_CNT_Z   = 4'd6,
    C_INT     = 4'd7,
    C_ZF      = 4'd8,
    C_NZF     = 4'd9,
    C_NOPB    = 4'd10,
    C_NINT    = 4'd11,
    C_NZXP    = 4'd12,
    C_RSV13   = 4'd13,
    C_RSV14   = 4'd14,
    C_NEVER   = 4'd15
  } cond_e;

  // Flags gathered from the latches for evaluation
  typedef struct packed {
    logic rep_act;
    logic rep_var;
    logic opc_bit;
    logic cnt_zero;
    logic int_ok;
    logic zf;
  } cond_flags_t;

endpackage

// File: rtl/useq_prefix_latch.sv
module useq_prefix_latch #(
  parameter int PFX_W   = 8,
  parameter int VAR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfx_strobe,
  input  logic             pfx_rep,
  input  logic [PFX_W-1:0] pfx_byte,
  input  logic             instr_end,
  input  logic             opcode_load,
  output logic             rep_act,
  output logic             rep_var,
  output logic             int_hold
);

  logic unused_pfx_bits;
  assign unused_pfx_bits = ^pfx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_act  <= 1'b0;
      rep_var  <= 1'b0;
      int_hold <= 1'b0;
    end else begin
      if (pfx_strobe && pfx_rep) begin
        rep_act <= 1'b1;
        rep_var <= pfx_byte[VAR_BIT];
      end else if (instr_end) begin
        rep_act <= 1'b0;
        rep_var <= 1'b0;
      end
      if (pfx_strobe) begin
        int_hold <= 1'b1;
      end else if (opcode_load) begin
        int_hold <= 1'b0;
      end
    end
  end

  p_rep_set_r3: assert property (@(posedge clk) disable iff (rst)
    (pfx_strobe && pfx_rep) |=> (rep_act && rep_var == $past(pfx_byte[VAR_BIT])));

  p_end_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (instr_end && !pfx_strobe) |=> (!rep_act && !rep_var));

  p_nonrep_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (pfx_strobe && !pfx_rep && !instr_end) |=> ($stable(rep_act) && $stable(rep_var)));

  p_int_hold_r7: assert property (@(posedge clk) disable iff (rst)
    pfx_strobe |=> int_hold);

endmodule

// File: rtl/useq_status_latch.sv
module useq_status_latch #(
  parameter int OPC_W   = 8,
  parameter int OPC_BIT = 3,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opcode_load,
  input  logic [OPC_W-1:0]  opcode_byte,
  input  logic              alu_res_we,
  input  logic [DATA_W-1:0] alu_res,
  output logic              opc_bit,
  output logic              cnt_zero
);

  logic [OPC_W-1:0] opc_q;
  logic             res_is_zero;

  assign res_is_zero = (alu_res == '0);
  assign opc_bit     = opc_q[OPC_BIT];

  logic unused_opc_bits;
  assign unused_opc_bits = ^opc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q    <= '0;
      cnt_zero <= 1'b1;
    end else begin
      if (opcode_load) opc_q    <= opcode_byte;
      if (alu_res_we)  cnt_zero <= res_is_zero;
    end
  end

  p_zero_keep_r6: assert property (@(posedge clk) disable iff (rst)
    !alu_res_we |=> $stable(cnt_zero));

  p_opc_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !opcode_load |=> $stable(opc_bit));

endmodule

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
  import useq_pkg::*;
(
  input  logic        [3:0] cond_sel,
  input  cond_flags_t       flags,
  output logic              cond_true
);

  cond_e sel;
  logic  zxp;

  assign sel = cond_e'(cond_sel);
  assign zxp = flags.zf ^ flags.rep_var;

  always_comb begin
    case (sel)
      C_ALWAYS: cond_true = 1'b1;
      C_REP:    cond_true = flags.rep_act;
      C_NREP:   cond_true = !flags.rep_act;
      C_ZXP:    cond_true = zxp;
      C_OPB:    cond_true = flags.opc_bit;
      C_CNT_NZ: cond_true = !flags.cnt_zero;
      C_CNT_Z:  cond_true = flags.cnt_zero;
      C_INT:    cond_true = flags.int_ok;
      C_ZF:     cond_true = flags.zf;
      C_NZF:    cond_true = !flags.zf;
      C_NOPB:   cond_true = !flags.opc_bit;
      C_NINT:   cond_true = !flags.int_ok;
      C_NZXP:   cond_true = !zxp;
      default:  cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_addr_reg.sv
module useq_addr_reg #(
  parameter int UADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seq_en,
  input  logic               entry_load,
  input  logic [UADDR_W-1:0] entry_addr,
  input  logic               jump_en,
  input  logic               call_en,
  input  logic               ret_en,
  input  logic               cond_true,
  input  logic [UADDR_W-1:0] jump_target,
  output logic [UADDR_W-1:0] upc,
  output logic               taken
);

  localparam logic [UADDR_W-1:0] STEP = UADDR_W'(1);

  logic [UADDR_W-1:0] ret_q;
  logic [UADDR_W-1:0] seq_nxt;
  logic               do_jump;

  assign seq_nxt = upc + STEP;
  assign do_jump = jump_en && cond_true;

  always_ff @(posedge clk) begin
    if (rst) begin
      upc   <= '0;
      ret_q <= '0;
      taken <= 1'b0;
    end else begin
      taken <= 1'b0;
      if (seq_en) begin
        if (entry_load) begin
          upc <= entry_addr;
        end else if (ret_en) begin
          upc <= ret_q;
        end else if (do_jump) begin
          upc   <= jump_target;
          taken <= 1'b1;
          if (call_en) ret_q <= seq_nxt;
        end else begin
          upc <= seq_nxt;
        end
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !seq_en |=> ($stable(upc) && !taken));

  p_seq_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_en && !entry_load && !ret_en && !(jump_en && cond_true))
      |=> (upc == $past(upc) + STEP && !taken));

  p_call_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_en && !entry_load && !ret_en && jump_en && call_en && cond_true)
      |=> (ret_q == $past(upc) + STEP));

  p_entry_r11: assert property (@(posedge clk) disable iff (rst)
    (seq_en && entry_load) |=> (upc == $past(entry_addr) && !taken));

endmodule

// File: rtl/useq_cond_seq.sv
module useq_cond_seq
  import useq_pkg::*;
#(
  parameter int UADDR_W = 9,
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int OPC_BIT = 3,
  parameter int VAR_BIT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seq_en,
  input  logic               entry_load,
  input  logic [UADDR_W-1:0] entry_addr,
  input  logic [3:0]         cond_sel,
  input  logic               jump_en,
  input  logic               call_en,
  input  logic               ret_en,
  input  logic [UADDR_W-1:0] jump_target,
  input  logic               pfx_strobe,
  input  logic               pfx_rep,
  input  logic [BYTE_W-1:0]  pfx_byte,
  input  logic               instr_end,
  input  logic               opcode_load,
  input  logic [BYTE_W-1:0]  opcode_byte,
  input  logic               alu_res_we,
  input  logic [DATA_W-1:0]  alu_res,
  input  logic               zf,
  input  logic               int_pending,
  output logic [UADDR_W-1:0] upc,
  output logic               cond_taken
);

  logic        rep_act, rep_var, int_hold;
  logic        opc_bit, cnt_zero;
  logic        cond_true;
  cond_flags_t flags;

  useq_prefix_latch #(
    .PFX_W   (BYTE_W),
    .VAR_BIT (VAR_BIT)
  ) u_pfx (
    .clk         (clk),
    .rst         (rst),
    .pfx_strobe  (pfx_strobe),
    .pfx_rep     (pfx_rep),
    .pfx_byte    (pfx_byte),
    .instr_end   (instr_end),
    .opcode_load (opcode_load),
    .rep_act     (rep_act),
    .rep_var     (rep_var),
    .int_hold    (int_hold)
  );

  useq_status_latch #(
    .OPC_W   (BYTE_W),
    .OPC_BIT (OPC_BIT),
    .DATA_W  (DATA_W)
  ) u_stat (
    .clk         (clk),
    .rst         (rst),
    .opcode_load (opcode_load),
    .opcode_byte (opcode_byte),
    .alu_res_we  (alu_res_we),
    .alu_res     (alu_res),
    .opc_bit     (opc_bit),
    .cnt_zero    (cnt_zero)
  );

  assign flags = '{rep_act:  rep_act,
                   rep_var:  rep_var,
                   opc_bit:  opc_bit,
                   cnt_zero: cnt_zero,
                   int_ok:   int_pending && !int_hold,
                   zf:       zf};

  useq_cond_eval u_eval (
    .cond_sel  (cond_sel),
    .flags     (flags),
    .cond_true (cond_true)
  );

  useq_addr_reg #(
    .UADDR_W (UADDR_W)
  ) u_addr (
    .clk         (clk),
    .rst         (rst),
    .seq_en      (seq_en),
    .entry_load  (entry_load),
    .entry_addr  (entry_addr),
    .jump_en     (jump_en),
    .call_en     (call_en),
    .ret_en      (ret_en),
    .cond_true   (cond_true),
    .jump_target (jump_target),
    .upc         (upc),
    .taken       (cond_taken)
  );

  p_never_r12: assert property (@(posedge clk) disable iff (rst)
    (seq_en && jump_en && cond_sel >= 4'd13) |=> !cond_taken);

  p_always_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_en && !entry_load && !ret_en && jump_en && cond_sel == 4'd0)
      |=> (cond_taken && upc == $past(jump_target)));

endmodule

// File: tb/useq_cond_seq_tb_top.sv
module useq_cond_seq_tb_top;

  localparam int UA = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          seq_en = 1'b0, entry_load = 1'b0;
  logic [UA-1:0] entry_addr = '0;
  logic [3:0]    cond_sel = '0;
  logic          jump_en = 1'b0, call_en = 1'b0, ret_en = 1'b0;
  logic [UA-1:0] jump_target = '0;
  logic          pfx_strobe = 1'b0, pfx_rep = 1'b0;
  logic [7:0]    pfx_byte = '0;
  logic          instr_end = 1'b0, opcode_load = 1'b0;
  logic [7:0]    opcode_byte = '0;
  logic          alu_res_we = 1'b0;
  logic [15:0]   alu_res = '0;
  logic          zf = 1'b0, int_pending = 1'b0;
  logic [UA-1:0] upc;
  logic          cond_taken;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [UA-1:0] q_pc[$];
  logic          q_tk[$];
  string         q_tag[$];

  always #10 clk = ~clk;

  useq_cond_seq dut_i (
    .clk(clk), .rst(rst), .seq_en(seq_en), .entry_load(entry_load),
    .entry_addr(entry_addr), .cond_sel(cond_sel), .jump_en(jump_en),
    .call_en(call_en), .ret_en(ret_en), .jump_target(jump_target),
    .pfx_strobe(pfx_strobe), .pfx_rep(pfx_rep), .pfx_byte(pfx_byte),
    .instr_end(instr_end), .opcode_load(opcode_load),
    .opcode_byte(opcode_byte), .alu_res_we(alu_res_we), .alu_res(alu_res),
    .zf(zf), .int_pending(int_pending), .upc(upc), .cond_taken(cond_taken)
  );

  // Start a new cycle: wait for the falling edge and drop all pulses
  task automatic nxt();
    @(negedge clk);
    seq_en = 1'b1; entry_load = 1'b0; jump_en = 1'b0; call_en = 1'b0;
    ret_en = 1'b0; pfx_strobe = 1'b0; pfx_rep = 1'b0; instr_end = 1'b0;
    opcode_load = 1'b0; alu_res_we = 1'b0;
  endtask

  // Drive the micro-instruction fields and queue the expected result
  task automatic uop(input logic je, input logic [3:0] cs,
                     input logic [UA-1:0] tg, input logic [UA-1:0] epc,
                     input logic etk, input string tag);
    jump_en = je; cond_sel = cs; jump_target = tg;
    q_pc.push_back(epc); q_tk.push_back(etk); q_tag.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [UA-1:0] apc,
                       input logic atk, input logic [UA-1:0] epc,
                       input logic etk);
    n_chk++;
    if (apc !== epc || atk !== etk) begin
      n_fail++;
      $display("FAIL %s: upc=%0h taken=%0b expected upc=%0h taken=%0b",
               tag, apc, atk, epc, etk);
    end
  endtask

  // Monitor: one register stage after each queued stimulus
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_pc.size() > 0) begin
        check(q_tag.pop_front(), upc, cond_taken, q_pc.pop_front(),
              q_tk.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", upc, cond_taken, 9'h000, 1'b0);
    rst = 1'b0;

    // R11: entry load beats a jump issued in the same cycle
    nxt(); entry_load = 1'b1; entry_addr = 9'h040;
    uop(1'b1, 4'd0, 9'h1FF, 9'h040, 1'b0, "R11 entry priority");
    nxt(); uop(1'b0, 4'd0, 9'h000, 9'h041, 1'b0, "R8 sequential");
    nxt(); uop(1'b1, 4'd0, 9'h100, 9'h100, 1'b1, "R2 always jump");
    nxt(); uop(1'b1, 4'd1, 9'h020, 9'h101, 1'b0, "R3 rep inactive");
    // R3: repeat prefix 0xF3 (bit0=1); code 2 still sees the old latch
    nxt(); pfx_strobe = 1'b1; pfx_rep = 1'b1; pfx_byte = 8'hF3;
    uop(1'b1, 4'd2, 9'h030, 9'h030, 1'b1, "R3 not-rep before load");
    nxt(); uop(1'b1, 4'd1, 9'h050, 9'h050, 1'b1, "R3 rep active");
    nxt(); zf = 1'b0; uop(1'b1, 4'd3, 9'h060, 9'h060, 1'b1, "R3 zf^var=1");
    nxt(); zf = 1'b1; uop(1'b1, 4'd3, 9'h070, 9'h061, 1'b0, "R3 zf^var=0");
    nxt(); uop(1'b1, 4'd12, 9'h068, 9'h068, 1'b1, "R3 complement zxp");
    // R4: non-repeat prefix is ignored by the latches
    nxt(); pfx_strobe = 1'b1; pfx_rep = 1'b0; pfx_byte = 8'h2E;
    uop(1'b0, 4'd0, 9'h000, 9'h069, 1'b0, "R4 nonrep prefix");
    nxt(); uop(1'b1, 4'd1, 9'h070, 9'h070, 1'b1, "R4 latch kept");
    nxt(); instr_end = 1'b1; uop(1'b0, 4'd0, 9'h000, 9'h071, 1'b0, "R4 end");
    nxt(); uop(1'b1, 4'd1, 9'h020, 9'h072, 1'b0, "R4 latch cleared");
    // R3: repeat prefix 0xF2 (bit0=0) makes code 3 follow zf directly
    nxt(); pfx_strobe = 1'b1; pfx_rep = 1'b1; pfx_byte = 8'hF2;
    uop(1'b0, 4'd0, 9'h000, 9'h073, 1'b0, "R3 load F2");
    nxt(); zf = 1'b1; uop(1'b1, 4'd3, 9'h080, 9'h080, 1'b1, "R3 zf^0");
    // R7: hold from the prefixes blocks the interrupt test
    nxt(); int_pending = 1'b1;
    uop(1'b1, 4'd7, 9'h090, 9'h081, 1'b0, "R7 int held");
    nxt(); opcode_load = 1'b1; opcode_byte = 8'hAC;
    uop(1'b1, 4'd11, 9'h0A0, 9'h0A0, 1'b1, "R7 held on load cycle");
    nxt(); uop(1'b1, 4'd7, 9'h090, 9'h090, 1'b1, "R7 int seen");
    // R5: opcode bit 3
    nxt(); int_pending = 1'b0;
    uop(1'b1, 4'd4, 9'h0B0, 9'h0B0, 1'b1, "R5 bit3=1");
    nxt(); opcode_load = 1'b1; opcode_byte = 8'hA4;
    uop(1'b0, 4'd0, 9'h000, 9'h0B1, 1'b0, "R5 load A4");
    nxt(); uop(1'b1, 4'd4, 9'h0C0, 9'h0B2, 1'b0, "R5 bit3=0");
    nxt(); uop(1'b1, 4'd10, 9'h0C0, 9'h0C0, 1'b1, "R5 complement");
    // R6: private count-zero record
    nxt(); alu_res_we = 1'b1; alu_res = 16'h0000;
    uop(1'b0, 4'd0, 9'h000, 9'h0C1, 1'b0, "R6 write zero");
    nxt(); zf = 1'b0; alu_res = 16'h0F0F;
    uop(1'b1, 4'd5, 9'h0D0, 9'h0C2, 1'b0, "R6 count zero");
    nxt(); uop(1'b1, 4'd6, 9'h0D0, 9'h0D0, 1'b1, "R6 zero code");
    nxt(); alu_res_we = 1'b1; alu_res = 16'h0100;
    uop(1'b0, 4'd0, 9'h000, 9'h0D1, 1'b0, "R6 write nonzero");
    nxt(); zf = 1'b1; uop(1'b1, 4'd5, 9'h0E0, 9'h0E0, 1'b1, "R6 nz ignores zf");
    // R9: call and return
    nxt(); call_en = 1'b1; uop(1'b1, 4'd0, 9'h150, 9'h150, 1'b1, "R9 call");
    nxt(); uop(1'b0, 4'd0, 9'h000, 9'h151, 1'b0, "R9 in subroutine");
    nxt(); ret_en = 1'b1; uop(1'b0, 4'd0, 9'h000, 9'h0E1, 1'b0, "R9 return");
    // R10: stall
    nxt(); seq_en = 1'b0; uop(1'b1, 4'd0, 9'h010, 9'h0E1, 1'b0, "R10 hold");
    nxt(); uop(1'b0, 4'd0, 9'h000, 9'h0E2, 1'b0, "R10 resume");
    // R12: never-satisfied codes and the plain zero flag
    nxt(); uop(1'b1, 4'd13, 9'h010, 9'h0E3, 1'b0, "R12 code13");
    nxt(); uop(1'b1, 4'd14, 9'h010, 9'h0E4, 1'b0, "R12 code14");
    nxt(); uop(1'b1, 4'd15, 9'h010, 9'h0E5, 1'b0, "R12 code15");
    nxt(); uop(1'b1, 4'd9, 9'h010, 9'h0E6, 1'b0, "R12 not zf");
    nxt(); uop(1'b1, 4'd8, 9'h011, 9'h011, 1'b1, "R12 zf");
    // R8: wrap at the top address
    nxt(); entry_load = 1'b1; entry_addr = 9'h1FF;
    uop(1'b0, 4'd0, 9'h000, 9'h1FF, 1'b0, "R11 entry top");
    nxt(); uop(1'b0, 4'd0, 9'h000, 9'h000, 1'b0, "R8 wrap");
    nxt(); uop(1'b0, 4'd0, 9'h000, 9'h001, 1'b0, "R8 after wrap");
    nxt();
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule